// File: doc/BRIEF.md
# Saturating Halfword and Word Add/Subtract Unit

This unit performs signed addition and subtraction for a datapath that handles both 32-bit words and 16-bit halfwords. A 3-bit operation code selects one of seven modes. The two plain halfword modes take either half of each operand, sign-extend it and form a full-width sum or difference that cannot overflow. The saturating modes clamp the result to the signed range instead of letting it wrap. These modes are word add, word subtract, low-halfword add, low-halfword subtract, and subtract of a sign-extended 16-bit immediate from the first operand.

A caller presents the operands, the immediate, the operation code and two part-select bits with a one-cycle `in_valid` strobe. One clock later the registered result appears together with a flag that reports whether clamping altered the value, and `out_valid` is high for that one cycle. Between strobes the result and flag keep their last values.

Top module: `sat_addsub_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `sat_flag` become 0.
- R2: The edge that samples `in_valid`=1 loads `result` and `sat_flag` and raises `out_valid` for one cycle. On an edge with `in_valid`=0, `out_valid` goes to 0 and `result` and `sat_flag` keep their values.
- R3: In modes 0 and 1, `sel_a_hi`=1 picks bits [31:16] of `op_a` and `sel_a_hi`=0 picks bits [15:0]. `sel_b_hi` picks the half of `op_b` in the same way.
- R4: Opcode 0 (halfword add) returns the sign-extended picked half of `op_a` plus the sign-extended picked half of `op_b`, as a 32-bit value with `sat_flag`=0.
- R5: Opcode 1 (halfword subtract) returns the sign-extended picked half of `op_a` minus that of `op_b`, as a 32-bit value with `sat_flag`=0.
- R6: Opcode 2 (saturating word add) returns `op_a`+`op_b`. A sum above 0x7FFFFFFF gives 0x7FFFFFFF and a sum below -2^31 gives 0x80000000.
- R7: Opcode 3 (saturating word subtract) returns `op_a`-`op_b`, clamped in the same way as R6.
- R8: Opcodes 4 (add) and 5 (subtract) use only bits [15:0] of each operand. They clamp to the range -32768..32767, sign-extend the clamped value to 32 bits, and ignore the part-select bits and bits [31:16].
- R9: Opcode 6 returns `op_a` minus the sign-extended `imm`, clamped to the signed 32-bit range. `op_b` has no effect.
- R10: Opcode 7 is reserved and returns `result`=0 with `sat_flag`=0.
- R11: `sat_flag` is 1 exactly when clamping replaced the exact signed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation code 0..7 |
| sel_a_hi | input | 1 | Half select for `op_a` in modes 0 and 1 |
| sel_b_hi | input | 1 | Half select for `op_b` in modes 0 and 1 |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| imm | input | 16 | Immediate for opcode 6 |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Clamping occurred |

## Verification
The hardest condition to reach from the ports is an overflow that sits exactly on a rail. Examples are subtracting 0x80000000 from zero, or subtracting the immediate 0x8000 from a value near the positive limit. Uniform random operands almost never produce these cases. The stimulus therefore draws each operand from a mix that favours values near the positive limit, near the negative limit and near zero. It also adds directed vectors that land one step beyond each limit, at 32 bits and at 16 bits.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;
  typedef enum logic [2:0] {
    OP_HADD  = 3'd0,
    OP_HSUB  = 3'd1,
    OP_SADDW = 3'd2,
    OP_SSUBW = 3'd3,
    OP_SADDH = 3'd4,
    OP_SSUBH = 3'd5,
    OP_SSUBI = 3'd6,
    OP_RSVD  = 3'd7
  } addsub_op_e;
endpackage

// File: rtl/sat_half_pick.sv
// Selects one half of a word and sign-extends it back to full width.
module sat_half_pick #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic              take_hi,
  output logic [DATA_W-1:0] ext_out
);
  localparam int HALF_W = DATA_W / 2;
  logic [HALF_W-1:0] half;

  always_comb begin
    half    = take_hi ? word_in[DATA_W-1:HALF_W] : word_in[HALF_W-1:0];
    ext_out = {{(DATA_W-HALF_W){half[HALF_W-1]}}, half};
  end
endmodule

// File: rtl/sat_addsub_core.sv
// Signed W-bit adder/subtractor with overflow detection and clamped output.
module sat_addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] raw_sum,
  output logic [W-1:0] sat_sum,
  output logic         ovf
);
  localparam logic [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff   = sub ? ~b : b;
    raw_sum = a + b_eff + {{(W-1){1'b0}}, sub};
    ovf     = (a[W-1] == b_eff[W-1]) && (raw_sum[W-1] != a[W-1]);
    if (ovf) sat_sum = a[W-1] ? NEG_RAIL : POS_RAIL;
    else     sat_sum = raw_sum;
  end
endmodule

// File: rtl/sat_out_reg.sv
// Output stage: loads on strobe, holds otherwise.
module sat_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_flag,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_result,
  output logic              q_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_flag   <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_result <= d_result;
        q_flag   <= d_flag;
      end
    end
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_addsub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [2:0]             opcode,
  input  logic                   sel_a_hi,
  input  logic                   sel_b_hi,
  input  logic [DATA_W-1:0]      op_a,
  input  logic [DATA_W-1:0]      op_b,
  input  logic [DATA_W/2-1:0]    imm,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      result,
  output logic                   sat_flag
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  addsub_op_e op;
  assign op = addsub_op_e'(opcode);

  // Halfword lane pickers for the plain halfword modes (R3)
  logic [DATA_W-1:0] pick_a, pick_b;
  sat_half_pick #(.DATA_W(DATA_W)) u_pick_a (.word_in(op_a), .take_hi(sel_a_hi), .ext_out(pick_a));
  sat_half_pick #(.DATA_W(DATA_W)) u_pick_b (.word_in(op_b), .take_hi(sel_b_hi), .ext_out(pick_b));

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{(DATA_W-HALF_W){imm[HALF_W-1]}}, imm};

  // Word-width datapath operand selection
  logic [DATA_W-1:0] w_a, w_b;
  logic              w_sub;
  always_comb begin
    w_a   = '0;
    w_b   = '0;
    w_sub = 1'b0;
    unique case (op)
      OP_HADD:  begin w_a = pick_a; w_b = pick_b; end
      OP_HSUB:  begin w_a = pick_a; w_b = pick_b; w_sub = 1'b1; end
      OP_SADDW: begin w_a = op_a;   w_b = op_b; end
      OP_SSUBW: begin w_a = op_a;   w_b = op_b;   w_sub = 1'b1; end
      OP_SSUBI: begin w_a = op_a;   w_b = imm_ext; w_sub = 1'b1; end
      default:  ;
    endcase
  end

  // Two adder widths built from one core through a generate loop
  localparam int NLANE = 2;
  logic [DATA_W-1:0] w_raw, w_sat;
  logic [HALF_W-1:0] h_raw, h_sat;
  logic              w_ovf, h_ovf;
  logic              h_sub;
  assign h_sub = (op == OP_SSUBH);

  for (genvar g = 0; g < NLANE; g++) begin : g_core
    if (g == 0) begin : g_word
      sat_addsub_core #(.W(DATA_W)) u_core (
        .a(w_a), .b(w_b), .sub(w_sub),
        .raw_sum(w_raw), .sat_sum(w_sat), .ovf(w_ovf));
    end else begin : g_half
      sat_addsub_core #(.W(HALF_W)) u_core (
        .a(op_a[HALF_W-1:0]), .b(op_b[HALF_W-1:0]), .sub(h_sub),
        .raw_sum(h_raw), .sat_sum(h_sat), .ovf(h_ovf));
    end
  end

  // Result and flag selection
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_flag;
  always_comb begin
    nxt_result = '0;
    nxt_flag   = 1'b0;
    unique case (op)
      OP_HADD, OP_HSUB: nxt_result = w_raw;
      OP_SADDW, OP_SSUBW, OP_SSUBI: begin
        nxt_result = w_sat;
        nxt_flag   = w_ovf;
      end
      OP_SADDH, OP_SSUBH: begin
        nxt_result = {{(DATA_W-HALF_W){h_sat[HALF_W-1]}}, h_sat};
        nxt_flag   = h_ovf;
      end
      default: ;
    endcase
  end

  sat_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(in_valid),
    .d_result(nxt_result), .d_flag(nxt_flag),
    .q_valid(out_valid), .q_result(result), .q_flag(sat_flag));

  // Assertions
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(sat_flag)));

  p_plain_noflag_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == 3'd0 || opcode == 3'd1)) |=> !sat_flag);

  p_word_rail_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == 3'd2 || opcode == 3'd3 || opcode == 3'd6))
      |=> (!sat_flag || result == WORD_MAX || result == WORD_MIN));

  p_half_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == 3'd4 || opcode == 3'd5))
      |=> (result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result[HALF_W-1]}}));

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd7) |=> (result == '0 && !sat_flag));
endmodule

// File: tb/sat_addsub_unit_bench.sv
module sat_addsub_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  opcode;
  logic        sel_a_hi, sel_b_hi;
  logic [31:0] op_a, op_b;
  logic [15:0] imm;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sat_addsub_unit u_sat_addsub_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi), .op_a(op_a), .op_b(op_b),
    .imm(imm), .out_valid(out_valid), .result(result), .sat_flag(sat_flag));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic longint sx16(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sx32(logic [31:0] v);
    return longint'($signed(v));
  endfunction

  // returns {flag, result}
  function automatic logic [32:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                                        logic [15:0] im, logic sa, logic sb);
    longint pa, pb, r, lo, hi;
    logic f;
    pa = sa ? sx16(a[31:16]) : sx16(a[15:0]);
    pb = sb ? sx16(b[31:16]) : sx16(b[15:0]);
    f  = 1'b0;
    lo = -64'sd2147483648;
    hi = 64'sd2147483647;
    case (op)
      3'd0: r = pa + pb;
      3'd1: r = pa - pb;
      3'd2: r = sx32(a) + sx32(b);
      3'd3: r = sx32(a) - sx32(b);
      3'd4: begin r = sx16(a[15:0]) + sx16(b[15:0]); lo = -32768; hi = 32767; end
      3'd5: begin r = sx16(a[15:0]) - sx16(b[15:0]); lo = -32768; hi = 32767; end
      3'd6: r = sx32(a) - sx16(im);
      default: r = 0;
    endcase
    if (op >= 3'd2 && op <= 3'd6) begin
      if (r > hi) begin r = hi; f = 1'b1; end
      if (r < lo) begin r = lo; f = 1'b1; end
    end
    return {f, r[31:0]};
  endfunction

  task automatic run(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                     logic [15:0] im, logic sa, logic sb);
    logic [32:0] e;
    logic [31:0] held;
    e = model(op, a, b, im, sa, sb);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; imm = im; sel_a_hi = sa; sel_b_hi = sb;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    op_a = $urandom; op_b = $urandom; imm = 16'($urandom); opcode = 3'($urandom);
    check("R2 out_valid", {31'd0, out_valid}, 32'd1);
    check(req_of(op), result, e[31:0]);
    check("R11 sat_flag", {31'd0, sat_flag}, {31'd0, e[32]});
    held = result;
    @(negedge clk);
    check("R2 drop", {31'd0, out_valid}, 32'd0);
    check("R2 hold", result, held);
    check("R2 hold flag", {31'd0, sat_flag}, {31'd0, e[32]});
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom % 5)
      0: return 32'h7FFF_FFFF - ($urandom % 8);
      1: return 32'h8000_0000 + ($urandom % 8);
      2: return {16'($urandom), 16'h7FF0 + 16'($urandom % 32)};
      3: return 32'($urandom % 16) - 32'd8;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; opcode = 3'd0; sel_a_hi = 1'b0; sel_b_hi = 1'b0;
    op_a = '0; op_b = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 sat_flag", {31'd0, sat_flag}, 32'd0);
    rst = 1'b0;

    // R3 / R4 / R5: lane selection and sign extension
    run(3'd0, 32'h8000_0001, 32'h8000_0002, 16'h0, 1'b1, 1'b1);   // R3 -> FFFF0000
    run(3'd0, 32'h8000_0001, 32'h8000_0002, 16'h0, 1'b0, 1'b0);   // R3 -> 3
    run(3'd0, 32'h1234_7FFF, 32'h7FFF_0000, 16'h0, 1'b0, 1'b1);   // R4 -> FFFE
    run(3'd1, 32'h8000_0000, 32'h0000_7FFF, 16'h0, 1'b1, 1'b0);   // R5 -> FFFF0001
    run(3'd1, 32'h0000_7FFF, 32'h8000_0000, 16'h0, 1'b0, 1'b1);   // R5 -> 0000FFFF
    // R6 / R7 rails
    run(3'd2, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 1'b0, 1'b0);
    run(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);
    run(3'd2, 32'h7FFF_FFFE, 32'h0000_0001, 16'h0, 1'b0, 1'b0);
    run(3'd3, 32'h0000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b0);
    run(3'd3, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b0);
    run(3'd3, 32'h8000_0000, 32'h0000_0001, 16'h0, 1'b0, 1'b0);
    // R8: high bits and selects ignored
    run(3'd4, 32'hABCD_7FFF, 32'h1234_0001, 16'h0, 1'b1, 1'b1);
    run(3'd4, 32'h5555_8000, 32'hAAAA_FFFF, 16'h0, 1'b1, 1'b0);
    run(3'd5, 32'h0000_0000, 32'hFFFF_8000, 16'h0, 1'b0, 1'b1);
    run(3'd5, 32'hFFFF_FFFE, 32'h0000_0003, 16'h0, 1'b1, 1'b1);
    // R9: immediate form, op_b ignored
    run(3'd6, 32'h7FFF_FFF0, 32'hDEAD_BEEF, 16'h8000, 1'b0, 1'b0);
    run(3'd6, 32'h8000_0000, 32'h1234_5678, 16'h0001, 1'b1, 1'b1);
    run(3'd6, 32'h0000_0010, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 1'b0);
    // R10 reserved
    run(3'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h7FFF, 1'b1, 1'b0);

    for (int i = 0; i < 400; i++) begin
      run(3'($urandom % 8), pick32(), pick32(), 16'($urandom),
          1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule